// File: doc/BRIEF.md
# Peripheral Window Access Decoder

This block sits between a CPU bus and a set of peripheral registers placed in the top 32 KiB of a 24-bit address space (0xFF8000 to 0xFFFFFF). It takes one byte, word or long-word read or write at a time and walks through it one byte lane per clock, lowest address first. Each byte is sorted into one of three classes: a mapped register, a silent hole that reads as 0xFF and swallows writes, or a bus-error hole. The sorting comes from a parameter table of up to 16 base/span entries and from three configuration inputs.

For every lane that lands on a mapped register, the block emits a select strobe with the byte address, the table entry index and the write byte. Bytes that belong to the same entry share one strobe. A bus error is reported only when every byte of the access fell in a bus-error hole, so a wide access that only partly covers a register reads as data. The sound-chip mirror range is folded onto its four base bytes before any decoding. The peripheral register logic and the CPU's exception handling are outside the block.

Top module: `io_window_decoder`

## Requirements
- R1: An access whose 24-bit address is below 0xFF8000 ends with done and bus_err high in the cycle after acceptance, with no select strobe and rdata equal to zero.
- R2: A word access at a base above 0xFFFFFE, a long access at a base above 0xFFFFFC, or size code 2'b11 ends with done and illegal high in the cycle after acceptance, with bus_err low, no strobe and rdata zero.
- R3: A base address from 0xFF8800 to 0xFF88FF is replaced by 0xFF8800 plus its two low bits, and the lanes continue upward from that replaced address.
- R4: Size codes are 2'b00 byte, 2'b01 word and 2'b10 long. An accepted access keeps busy high for one cycle per byte and raises done for one cycle after the last lane. A request presented while busy is ignored.
- R5: bus_err is raised with done only when the number of lanes that hit a bus-error hole equals the access size. Any address that no table entry covers is a bus-error hole.
- R6: Read data is right-aligned and big-endian: the lowest address lands in the most significant returned byte. A mapped lane returns reg_rdata, and a hole lane returns 0xFF. rdata is zero after a write.
- R7: A write to a silent hole produces no strobe and no bus error.
- R8: With cfg_base_variant high and cfg_blit_en low, 0xFF8A00 to 0xFF8A3F become bus-error holes. With cfg_base_variant low, that range stays mapped.
- R9: With cfg_rtc_en low, 0xFFFC21 to 0xFFFC3F become silent holes, while 0xFFFC20 stays mapped.
- R10: A run of lanes inside one table entry gives a single strobe, on its first lane. Each change of entry gives a new strobe, carrying that lane's address and the entry index.
- R11: For a write, wr_lanes holds the whole right-aligned write word from the first lane cycle and stays stable until the access ends. sel_wbyte carries the byte for the current lane.
- R12: When table entries overlap, the higher-numbered entry decides the index. The default table maps 0xFF820A to 0xFF820B as entry 2 over entry 1 at 0xFF8200 to 0xFF823F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 00 byte, 01 word, 10 long |
| req_addr | input | 24 | Byte base address |
| req_wdata | input | 32 | Right-aligned write data |
| cfg_base_variant | input | 1 | Base machine variant selected |
| cfg_blit_en | input | 1 | Blitter present |
| cfg_rtc_en | input | 1 | Real-time clock present |
| reg_rdata | input | 8 | Byte returned by the addressed register in the current lane |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished (one-cycle pulse) |
| bus_err | output | 1 | Bus error, valid with done |
| illegal | output | 1 | Rejected access, valid with done |
| rdata | output | 32 | Read result, valid with done |
| wr_lanes | output | 32 | Write word held for the access |
| sel_valid | output | 1 | Register select strobe |
| sel_write | output | 1 | Current access is a write |
| sel_addr | output | 24 | Byte address of the current lane |
| sel_idx | output | 4 | Table entry of the current lane |
| sel_wbyte | output | 8 | Write byte of the current lane |

## Verification
The assertions assume that the configuration inputs change only while the block is idle, because a change in the middle of an access would reclassify later lanes. They also assume that reset is held for at least one clock edge. The bench changes configuration only between accesses, after done has been seen. It drives requests on the falling edge, and it presents a second request during a busy period on purpose to show that the request is dropped.

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int MAP_N = 9,
  parameter logic [MAP_N*24-1:0] MAP_BASE = {24'hFFFC20, 24'hFFFC00, 24'hFFFA00,
                                             24'hFF8A00, 24'hFF8800, 24'hFF8600,
                                             24'hFF820A, 24'hFF8200, 24'hFF8000},
  parameter logic [MAP_N*8-1:0]  MAP_SPAN = {8'h20, 8'h08, 8'h40, 8'h40, 8'h04,
                                             8'h10, 8'h02, 8'h40, 8'h02}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        cfg_base_variant,
  input  logic        cfg_blit_en,
  input  logic        cfg_rtc_en,
  input  logic [7:0]  reg_rdata,
  output logic        busy,
  output logic        done,
  output logic        bus_err,
  output logic        illegal,
  output logic [31:0] rdata,
  output logic [31:0] wr_lanes,
  output logic        sel_valid,
  output logic        sel_write,
  output logic [23:0] sel_addr,
  output logic [3:0]  sel_idx,
  output logic [7:0]  sel_wbyte
);
  localparam logic [23:0] WIN_LO = 24'hFF8000;
  localparam logic [15:0] MIR_PG = 16'hFF88;
  localparam logic [23:0] BLT_LO = 24'hFF8A00, BLT_HI = 24'hFF8A3F;
  localparam logic [23:0] RTC_LO = 24'hFFFC21, RTC_HI = 24'hFFFC3F;

  logic [23:0] base_q, cur;
  logic [1:0]  lane_q, last_q, pos;
  logic [2:0]  cnt_q, cnt_nxt;
  logic        wr_q, prev_map_q, last_lane;
  logic [3:0]  prev_idx_q;
  logic [31:0] acc_q;
  logic        hit, blit_off, rtc_off, is_map, is_berr;
  logic [3:0]  idx;
  logic [7:0]  lane_byte;

  wire below = req_addr < WIN_LO;
  wire bad   = (req_size == 2'b01 && req_addr > 24'hFFFFFE) ||
               (req_size == 2'b10 && req_addr > 24'hFFFFFC) || (req_size == 2'b11);
  wire [23:0] folded = (req_addr[23:8] == MIR_PG) ? {MIR_PG, 6'd0, req_addr[1:0]} : req_addr;
  wire [1:0]  n_last = (req_size == 2'b00) ? 2'd0 : (req_size == 2'b01) ? 2'd1 : 2'd3;

  assign cur = base_q + {22'd0, lane_q};

  always_comb begin
    hit = 1'b0;
    idx = 4'd0;
    for (int i = 0; i < MAP_N; i++) begin
      if ({1'b0, cur} >= {1'b0, MAP_BASE[i*24 +: 24]} &&
          {1'b0, cur} <  {1'b0, MAP_BASE[i*24 +: 24]} + {17'd0, MAP_SPAN[i*8 +: 8]}) begin
        hit = 1'b1;
        idx = 4'(i);
      end
    end
  end

  assign blit_off  = cfg_base_variant && !cfg_blit_en && cur >= BLT_LO && cur <= BLT_HI;
  assign rtc_off   = !cfg_rtc_en && cur >= RTC_LO && cur <= RTC_HI;
  assign is_map    = hit && !blit_off && !rtc_off;
  assign is_berr   = blit_off || (!hit && !rtc_off);
  assign cnt_nxt   = cnt_q + {2'd0, is_berr};
  assign last_lane = lane_q == last_q;
  assign lane_byte = is_map ? reg_rdata : 8'hFF;
  assign pos       = last_q - lane_q;

  assign sel_valid = busy && is_map && (lane_q == 2'd0 || !prev_map_q || prev_idx_q != idx);
  assign sel_write = busy && wr_q;
  assign sel_addr  = cur;
  assign sel_idx   = idx;
  assign sel_wbyte = wr_lanes[{pos, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; bus_err <= 1'b0; illegal <= 1'b0;
      rdata <= '0; wr_lanes <= '0; acc_q <= '0; base_q <= '0;
      lane_q <= '0; last_q <= '0; cnt_q <= '0; wr_q <= 1'b0;
      prev_map_q <= 1'b0; prev_idx_q <= '0;
    end else begin
      done <= 1'b0; bus_err <= 1'b0; illegal <= 1'b0;
      if (!busy && req_valid) begin
        rdata    <= '0;
        acc_q    <= '0;
        wr_lanes <= req_write ? req_wdata : 32'd0;
        wr_q     <= req_write;
        base_q   <= folded;
        last_q   <= n_last;
        lane_q   <= '0;
        cnt_q    <= '0;
        if (below) begin
          done <= 1'b1; bus_err <= 1'b1;
        end else if (bad) begin
          done <= 1'b1; illegal <= 1'b1;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        prev_map_q <= is_map;
        prev_idx_q <= idx;
        cnt_q      <= cnt_nxt;
        lane_q     <= lane_q + 2'd1;
        if (!wr_q) acc_q <= {acc_q[23:0], lane_byte};
        if (last_lane) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          bus_err <= cnt_nxt == ({1'b0, last_q} + 3'd1);
          rdata   <= wr_q ? 32'd0 : {acc_q[23:0], lane_byte};
        end
      end
    end
  end
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        bus_err,
  input logic        illegal,
  input logic        sel_valid,
  input logic [23:0] sel_addr,
  input logic [31:0] wr_lanes
);
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err || illegal) |-> done);
  assert_err_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && illegal));
  assert_done_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_sel_in_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> busy);
  assert_lanes_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_lanes));
  assert_sel_folded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_addr >= 24'hFF8000 &&
                   !(sel_addr[23:8] == 16'hFF88 && sel_addr[7:2] != 6'd0)));
endmodule

bind io_window_decoder io_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_err(bus_err),
  .illegal(illegal), .sel_valid(sel_valid), .sel_addr(sel_addr), .wr_lanes(wr_lanes)
);

// File: tb/io_window_decoder_tb.sv
module io_window_decoder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_write;
  logic [1:0]  req_size;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        cfg_base_variant, cfg_blit_en, cfg_rtc_en;
  logic [7:0]  reg_rdata;
  logic        busy, done, bus_err, illegal, sel_valid, sel_write;
  logic [31:0] rdata, wr_lanes;
  logic [23:0] sel_addr;
  logic [3:0]  sel_idx;
  logic [7:0]  sel_wbyte;

  io_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_base_variant(cfg_base_variant), .cfg_blit_en(cfg_blit_en), .cfg_rtc_en(cfg_rtc_en),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .bus_err(bus_err), .illegal(illegal),
    .rdata(rdata), .wr_lanes(wr_lanes), .sel_valid(sel_valid), .sel_write(sel_write),
    .sel_addr(sel_addr), .sel_idx(sel_idx), .sel_wbyte(sel_wbyte)
  );

  assign reg_rdata = sel_addr[7:0] ^ 8'h5A;

  int n_run = 0, n_fail = 0;
  logic [33:0] res_q[$];
  string       res_tag[$];
  logic [36:0] sel_q[$];
  string       sel_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (res_q.size() == 0) chk(1'b0, "R4 unexpected done", 64'(rdata), 64'd0);
        else begin
          logic [33:0] e;
          string t;
          e = res_q.pop_front();
          t = res_tag.pop_front();
          chk({rdata, bus_err, illegal} == e, t, 64'({rdata, bus_err, illegal}), 64'(e));
        end
      end
      if (sel_valid) begin
        if (sel_q.size() == 0) chk(1'b0, "R10 unexpected strobe", 64'(sel_addr), 64'd0);
        else begin
          logic [36:0] e;
          string t;
          e = sel_q.pop_front();
          t = sel_tag.pop_front();
          chk({sel_addr, sel_idx, sel_write, sel_wbyte} == e, t,
              64'({sel_addr, sel_idx, sel_write, sel_wbyte}), 64'(e));
        end
      end
    end
  end

  task automatic exp_sel(input logic [23:0] a, input logic [3:0] i, input bit w,
                         input logic [7:0] b, input string tag);
    sel_q.push_back({a, i, w, b});
    sel_tag.push_back(tag);
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [23:0] a,
                        input logic [31:0] wd, input logic [31:0] er, input bit eb,
                        input bit ei, input int lat, input bit poke, input string tag);
    int c;
    res_q.push_back({er, eb, ei});
    res_tag.push_back(tag);
    while (busy) @(negedge clk);
    req_write = w; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    if (poke) begin
      req_write = 1'b0; req_size = 2'b00; req_addr = 24'hFF8100; req_valid = 1'b1;
    end
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b0;
      c++;
    end
    if (lat != 0) chk(c == lat, {tag, " latency"}, 64'(c), 64'(lat));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
    req_addr = '0; req_wdata = '0;
    cfg_base_variant = 1'b1; cfg_blit_en = 1'b1; cfg_rtc_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, sel_valid} == 3'b000, "R4 reset state", 64'({busy, done, sel_valid}), 64'd0);

    exp_sel(24'hFF820B, 4'd2, 1'b0, 8'h00, "R12 override strobe");
    access(0, 2'b00, 24'hFF820B, 0, 32'h51, 0, 0, 2, 0, "R12 byte read");
    access(0, 2'b00, 24'hFF8100, 0, 32'hFF, 1, 0, 2, 0, "R5 byte hole faults");
    exp_sel(24'hFF8001, 4'd0, 1'b0, 8'h00, "R5 partial strobe");
    access(0, 2'b01, 24'hFF8001, 0, 32'h5BFF, 0, 0, 3, 0, "R5 R6 partial word");
    access(0, 2'b10, 24'hFF8100, 0, 32'hFFFFFFFF, 1, 0, 5, 0, "R5 long hole faults");
    exp_sel(24'hFF8208, 4'd1, 1'b0, 8'h00, "R10 first span");
    exp_sel(24'hFF820A, 4'd2, 1'b0, 8'h00, "R10 second span");
    access(0, 2'b10, 24'hFF8208, 0, 32'h52535051, 0, 0, 5, 0, "R6 R10 long read");
    exp_sel(24'hFF8800, 4'd4, 1'b0, 8'h00, "R10 single strobe");
    access(0, 2'b01, 24'hFF8800, 0, 32'h5A5B, 0, 0, 0, 0, "R10 word in one span");
    exp_sel(24'hFF8802, 4'd4, 1'b0, 8'h00, "R3 fold strobe");
    access(0, 2'b00, 24'hFF88F6, 0, 32'h58, 0, 0, 0, 0, "R3 byte mirror");
    exp_sel(24'hFF8802, 4'd4, 1'b0, 8'h00, "R3 fold long strobe");
    access(0, 2'b10, 24'hFF88FE, 0, 32'h5859FFFF, 0, 0, 0, 0, "R3 long mirror");
    access(0, 2'b00, 24'h123456, 0, 32'h0, 1, 0, 1, 0, "R1 below window");
    access(1, 2'b10, 24'h000010, 32'h1, 32'h0, 1, 0, 1, 0, "R1 below window write");
    access(0, 2'b01, 24'hFFFFFF, 0, 32'h0, 0, 1, 1, 0, "R2 word at top");
    access(0, 2'b10, 24'hFFFFFD, 0, 32'h0, 0, 1, 1, 0, "R2 long past top");
    access(0, 2'b11, 24'hFF8000, 0, 32'h0, 0, 1, 1, 0, "R2 bad size");
    access(0, 2'b10, 24'hFFFFFC, 0, 32'hFFFFFFFF, 1, 0, 5, 0, "R2 long at limit");
    exp_sel(24'hFF8800, 4'd4, 1'b1, 8'hAB, "R11 word write byte");
    access(1, 2'b01, 24'hFF8800, 32'h0000ABCD, 32'h0, 0, 0, 3, 0, "R11 word write");
    exp_sel(24'hFF8208, 4'd1, 1'b1, 8'h11, "R11 long write lane0");
    exp_sel(24'hFF820A, 4'd2, 1'b1, 8'h33, "R11 long write lane2");
    access(1, 2'b10, 24'hFF8208, 32'h11223344, 32'h0, 0, 0, 5, 0, "R11 long write");
    access(0, 2'b10, 24'hFF8100, 0, 32'hFFFFFFFF, 1, 0, 5, 1, "R4 request while busy ignored");

    exp_sel(24'hFFFC21, 4'd8, 1'b0, 8'h00, "R9 rtc enabled strobe");
    access(0, 2'b00, 24'hFFFC21, 0, 32'h7B, 0, 0, 0, 0, "R9 rtc enabled read");
    cfg_rtc_en = 1'b0;
    access(0, 2'b00, 24'hFFFC21, 0, 32'hFF, 0, 0, 0, 0, "R9 rtc silent read");
    access(1, 2'b00, 24'hFFFC30, 32'h77, 32'h0, 0, 0, 0, 0, "R7 silent write");
    exp_sel(24'hFFFC20, 4'd8, 1'b0, 8'h00, "R9 kept byte strobe");
    access(0, 2'b00, 24'hFFFC20, 0, 32'h7A, 0, 0, 0, 0, "R9 kept byte");
    cfg_rtc_en = 1'b1;

    cfg_blit_en = 1'b0;
    access(0, 2'b00, 24'hFF8A00, 0, 32'hFF, 1, 0, 0, 0, "R8 blitter off faults");
    access(1, 2'b01, 24'hFF8A10, 32'h1234, 32'h0, 1, 0, 0, 0, "R8 blitter off write");
    cfg_base_variant = 1'b0;
    exp_sel(24'hFF8A00, 4'd5, 1'b0, 8'h00, "R8 other variant strobe");
    access(0, 2'b00, 24'hFF8A00, 0, 32'h5A, 0, 0, 0, 0, "R8 other variant mapped");
    cfg_base_variant = 1'b1; cfg_blit_en = 1'b1;

    repeat (4) @(negedge clk);
    chk(res_q.size() == 0, "R4 results pending", 64'(res_q.size()), 64'd0);
    chk(sel_q.size() == 0, "R10 strobes missing", 64'(sel_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule